// File: doc/BRIEF.md
# Host Port Memory Access Interface

This block is a slave port that lets an external host processor reach a device's internal memory over a 16-bit bidirectional bus driven by asynchronous, active-low strobes. The host selects one of four registers with two address lines. Through the data register it moves words to and from memory at an address held in a pointer. That pointer steps forward by itself after every data access, so a block transfer needs only one load of the pointer.

The block also carries a two-way mailbox. The local processor posts a word for the host, which raises an interrupt toward the host. The host posts a word back, which sets a flag and sends a one-cycle notification to the local side. A status register shows both mailbox flags and a set of external status inputs. A configuration input exchanges the two bytes of every word that moves between the host bus and memory.

The host strobes cross into the system clock through two-flop synchronisers. Every action fires on the deasserting (rising) edge of a read or write strobe, and only while chip select is low. Memory is a synchronous port with one cycle of read latency. The word at the pointer is always being prefetched, so read data is ready before the host ends its strobe.

Top module: `host_mem_port`

## Requirements
- R1: The register select `host_sel` decodes as 0 = memory data window, 1 = mailbox, 2 = address pointer, 3 = status. The block drives `host_data` only while `host_cs_n` and `host_rd_n` are both low, and the value it drives is the selected register.
- R2: A host write or read takes effect on the rising edge of its strobe, and only when `host_cs_n` is low. A strobe with chip select high changes neither memory nor the pointer.
- R3: A host write to register 0 stores the word in memory at word index `pointer >> 1`. `mem_addr` carries the byte-address pointer.
- R4: Every read or write of register 0 adds 2 to the pointer. Accesses to registers 1, 2 (reads) and 3 leave it unchanged.
- R5: A host write to register 2 loads the pointer with bit 0 forced to 0. A host read of register 2 returns the current pointer.
- R6: A local write on `loc_out_wr` stores `loc_out_data` and sets the outgoing flag. `host_irq` follows that flag. A host read of register 1 returns the stored word and clears the flag.
- R7: A host write to register 1 makes the word visible on `loc_in_data`, sets the incoming flag and gives exactly one cycle of `loc_in_pulse`. `loc_in_rd` clears the flag.
- R8: A status read returns bit 0 = outgoing flag, bit 1 = incoming flag, and bits 15:2 = `stat_in`. Host writes to register 3 are ignored.
- R9: With `cfg_swap` = 1, bits 15:8 and 7:0 are exchanged on words written to memory and on words read from memory. With `cfg_swap` = 0, words pass unchanged.
- R10: After reset the pointer is 0, both mailbox flags are 0 and `host_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_swap | input | 1 | Byte exchange on the memory data path |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_sel | input | 2 | Host register select |
| host_data | inout | 16 | Host data bus |
| host_irq | output | 1 | Outgoing-mailbox interrupt to the host |
| mem_addr | output | 16 | Memory byte address (the pointer) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after address |
| loc_out_wr | input | 1 | Local write of the outgoing mailbox |
| loc_out_data | input | 16 | Outgoing mailbox word |
| loc_in_rd | input | 1 | Local acknowledge, clears the incoming flag |
| loc_in_data | output | 16 | Incoming mailbox word |
| loc_in_pulse | output | 1 | One-cycle notice of a host mailbox write |
| stat_in | input | 14 | External status bits |

## Verification
The case that is hardest to set up from the ports is a host strobe that rises while chip select is high. A naive port would act on it. In this block the synchroniser is meant to suppress it, and no output shows that directly. The bench pulses write strobes to the pointer and to the data window with chip select held high. It then reads the pointer back and inspects the memory model to prove that nothing moved. The bench also interleaves the two byte orders over the same memory region, so that a swap applied on only one direction shows up as a mismatch.

// File: rtl/host_mem_port_pkg.sv
package host_mem_port_pkg;
   typedef enum logic [1:0] {
      HREG_DATA = 2'd0,
      HREG_MBOX = 2'd1,
      HREG_PTR  = 2'd2,
      HREG_STAT = 2'd3
   } hreg_e;

   localparam int unsigned FLAG_BITS = 2;
endpackage

// File: rtl/hmp_strobe_sync.sv
module hmp_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic level_n,
   output logic rise
);
   localparam int CHAIN = STAGES + 1;

   logic [CHAIN-1:0] q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("hmp_strobe_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < CHAIN; i++) begin : g_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b1;
            else if (i == 0) q[i] <= strobe_n;
            else q[i] <= q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign level_n = q[STAGES-1];
   assign rise    = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/hmp_lane_swap.sv
module hmp_lane_swap #(
   parameter int DW      = 16,
   parameter bit SUPPORT = 1'b1
) (
   input  logic          en,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   localparam int HALF = DW / 2;

   generate
      if (SUPPORT) begin : g_swap
         assign dout = en ? {din[HALF-1:0], din[DW-1:HALF]} : din;
      end else begin : g_pass
         logic unused_en;
         assign unused_en = en;
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/hmp_mailbox.sv
module hmp_mailbox #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          loc_wr,
   input  logic [DW-1:0] loc_wdata,
   input  logic          host_rd_clr,
   input  logic          host_wr_set,
   input  logic [DW-1:0] host_wdata,
   input  logic          loc_ack,
   output logic [DW-1:0] out_word,
   output logic          out_full,
   output logic [DW-1:0] in_word,
   output logic          in_full,
   output logic          in_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_word <= '0;
         out_full <= 1'b0;
      end else if (loc_wr) begin
         out_word <= loc_wdata;
         out_full <= 1'b1;
      end else if (host_rd_clr) begin
         out_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_word  <= '0;
         in_full  <= 1'b0;
         in_pulse <= 1'b0;
      end else begin
         in_pulse <= host_wr_set;
         if (host_wr_set) begin
            in_word <= host_wdata;
            in_full <= 1'b1;
         end else if (loc_ack) begin
            in_full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
   import host_mem_port_pkg::*;
#(
   parameter int DW           = 16,
   parameter int AW           = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_swap,
   input  logic               host_cs_n,
   input  logic               host_rd_n,
   input  logic               host_wr_n,
   input  logic [1:0]         host_sel,
   inout  wire  [DW-1:0]      host_data,
   output logic               host_irq,
   output logic [AW-1:0]      mem_addr,
   output logic               mem_we,
   output logic [DW-1:0]      mem_wdata,
   input  logic [DW-1:0]      mem_rdata,
   input  logic               loc_out_wr,
   input  logic [DW-1:0]      loc_out_data,
   input  logic               loc_in_rd,
   output logic [DW-1:0]      loc_in_data,
   output logic               loc_in_pulse,
   input  logic [DW-FLAG_BITS-1:0] stat_in
);
   localparam int          SW   = DW - FLAG_BITS;
   localparam logic [AW-1:0] STEP = AW'(2);

   generate
      if (DW < 4 || (DW % 2) != 0) begin : g_bad_dw
         $error("host_mem_port: DW must be even and at least 4");
      end
      if (AW < 2 || AW > DW) begin : g_bad_aw
         $error("host_mem_port: AW must lie between 2 and DW");
      end
   endgenerate

   // strobe synchronisation
   logic cs_lvl_n, cs_rise_unused, rd_lvl_unused, wr_lvl_unused;
   logic rd_rise, wr_rise;

   hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(host_cs_n),
      .level_n(cs_lvl_n), .rise(cs_rise_unused));
   hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n),
      .level_n(rd_lvl_unused), .rise(rd_rise));
   hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n),
      .level_n(wr_lvl_unused), .rise(wr_rise));

   logic  wr_evt, rd_evt, data_evt, mbox_rd_evt, mbox_wr_evt;
   hreg_e sel;

   assign sel         = hreg_e'(host_sel);
   assign wr_evt      = wr_rise & ~cs_lvl_n;
   assign rd_evt      = rd_rise & ~cs_lvl_n;
   assign data_evt    = (wr_evt | rd_evt) & (sel == HREG_DATA);
   assign mbox_rd_evt = rd_evt & (sel == HREG_MBOX);
   assign mbox_wr_evt = wr_evt & (sel == HREG_MBOX);

   // address pointer
   logic [AW-1:0] ptr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else if (wr_evt && sel == HREG_PTR)
         ptr_q <= {host_data[AW-1:1], 1'b0};
      else if (data_evt)
         ptr_q <= ptr_q + STEP;
   end

   // memory data path with optional byte exchange
   logic [DW-1:0] host_in, rd_mem_word;

   assign host_in = host_data;

   hmp_lane_swap #(.DW(DW), .SUPPORT(SWAP_SUPPORT)) u_swap_wr (
      .en(cfg_swap), .din(host_in), .dout(mem_wdata));
   hmp_lane_swap #(.DW(DW), .SUPPORT(SWAP_SUPPORT)) u_swap_rd (
      .en(cfg_swap), .din(mem_rdata), .dout(rd_mem_word));

   assign mem_addr = ptr_q;
   assign mem_we   = wr_evt & (sel == HREG_DATA);

   // mailbox
   logic [DW-1:0] out_word;
   logic          out_full, in_full;

   hmp_mailbox #(.DW(DW)) u_mbox (
      .clk(clk), .rst_n(rst_n),
      .loc_wr(loc_out_wr), .loc_wdata(loc_out_data),
      .host_rd_clr(mbox_rd_evt), .host_wr_set(mbox_wr_evt),
      .host_wdata(host_in), .loc_ack(loc_in_rd),
      .out_word(out_word), .out_full(out_full),
      .in_word(loc_in_data), .in_full(in_full),
      .in_pulse(loc_in_pulse));

   assign host_irq = out_full;

   // host read mux and bus drive
   logic [DW-1:0] rd_word;
   logic          drive_en;

   always_comb begin
      unique case (sel)
         HREG_DATA: rd_word = rd_mem_word;
         HREG_MBOX: rd_word = out_word;
         HREG_PTR:  rd_word = DW'(ptr_q);
         HREG_STAT: rd_word = {stat_in, in_full, out_full};
         default:   rd_word = '0;
      endcase
   end

   assign drive_en  = ~host_cs_n & ~host_rd_n;
   assign host_data = drive_en ? rd_word : 'z;

   logic unused_sig;
   assign unused_sig = cs_rise_unused ^ rd_lvl_unused ^ wr_lvl_unused;
endmodule

// File: rtl/host_mem_port_chk.sv
module host_mem_port_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_irq,
   input logic          mem_we,
   input logic          loc_out_wr,
   input logic          loc_in_pulse,
   input logic          data_evt,
   input logic          mbox_rd_evt,
   input logic [AW-1:0] ptr
);
   // R4: each data window access advances the pointer by two
   a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      data_evt |=> ptr == $past(ptr) + AW'(2));

   // R3: a memory write happens only as a data window access
   a_r3_we_is_data: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> data_evt);

   // R2: one strobe edge gives one write, never two in a row
   a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R6: a local post raises the host interrupt
   a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
      loc_out_wr |=> host_irq);

   // R6: a host mailbox read drops the interrupt
   a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_rd_evt && !loc_out_wr) |=> !host_irq);

   // R7: the local notification lasts one cycle
   a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      loc_in_pulse |=> !loc_in_pulse);
endmodule

bind host_mem_port host_mem_port_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_irq(host_irq), .mem_we(mem_we),
   .loc_out_wr(loc_out_wr), .loc_in_pulse(loc_in_pulse),
   .data_evt(data_evt), .mbox_rd_evt(mbox_rd_evt), .ptr(ptr_q));

// File: tb/host_mem_port_bench.sv
`timescale 1ns/1ps
module host_mem_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_swap = 1'b0;
   logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
   logic [1:0]  host_sel = 2'd0;
   wire  [15:0] host_data;
   logic        tb_oe = 1'b0;
   logic [15:0] tb_dout = '0;
   logic        host_irq;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we;
   logic        loc_out_wr = 1'b0;
   logic [15:0] loc_out_data = '0;
   logic        loc_in_rd = 1'b0;
   logic [15:0] loc_in_data;
   logic        loc_in_pulse;
   logic [13:0] stat_in = 14'h2A5C;

   int tests = 0, fails = 0, pulse_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   assign host_data = tb_oe ? tb_dout : 'z;

   host_mem_port u_host_mem_port (
      .clk(clk), .rst_n(rst_n), .cfg_swap(cfg_swap),
      .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
      .host_sel(host_sel), .host_data(host_data), .host_irq(host_irq),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .loc_out_wr(loc_out_wr),
      .loc_out_data(loc_out_data), .loc_in_rd(loc_in_rd),
      .loc_in_data(loc_in_data), .loc_in_pulse(loc_in_pulse),
      .stat_in(stat_in));

   logic [15:0] mem [0:255];
   always_ff @(posedge clk) begin
      if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[8:1]];
   end

   always @(posedge clk) if (loc_in_pulse) pulse_cnt++;

   function automatic logic [15:0] swp(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction
   function automatic logic [15:0] fpat(input int i);
      return 16'(i * 16'h1357) ^ 16'hA5C3;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] s, input logic [15:0] v, input bit cs_on);
      @(negedge clk);
      host_sel = s; tb_dout = v; tb_oe = 1'b1; host_cs_n = ~cs_on;
      @(negedge clk); host_wr_n = 1'b0;
      repeat (4) @(negedge clk);
      host_wr_n = 1'b1;
      repeat (6) @(negedge clk);
      host_cs_n = 1'b1; tb_oe = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic host_read(input logic [1:0] s, output logic [15:0] v);
      @(negedge clk);
      host_sel = s; host_cs_n = 1'b0; host_rd_n = 1'b0;
      repeat (4) @(negedge clk);
      v = host_data;
      host_rd_n = 1'b1;
      repeat (6) @(negedge clk);
      host_cs_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R10 reset state
      check("R10 irq after reset", {15'h0, host_irq}, 16'h0);
      host_read(2'd2, r); check("R10 pointer after reset", r, 16'h0);
      host_read(2'd3, r); check("R10 flags after reset", r, {14'h2A5C, 2'b00});

      // R5 load with odd value
      host_write(2'd2, 16'h0013, 1'b1);
      host_read(2'd2, r); check("R5 pointer load bit0 cleared", r, 16'h0012);

      // R3 R4 block write
      host_write(2'd2, 16'h0040, 1'b1);
      for (int i = 0; i < 32; i++) host_write(2'd0, fpat(i), 1'b1);
      for (int i = 0; i < 32; i++) check("R3 block write stored", mem[8'h20 + i], fpat(i));
      host_read(2'd2, r); check("R4 pointer after 32 writes", r, 16'h0080);

      // R1 R4 block read
      host_write(2'd2, 16'h0040, 1'b1);
      for (int i = 0; i < 32; i++) begin
         host_read(2'd0, r); check("R1 block read data", r, fpat(i));
      end
      host_read(2'd3, r);
      host_read(2'd1, r);
      host_read(2'd2, r); check("R4 pointer unchanged by other regs", r, 16'h0080);

      // R9 byte exchange
      cfg_swap = 1'b1;
      host_write(2'd2, 16'h0100, 1'b1);
      for (int i = 0; i < 16; i++) host_write(2'd0, fpat(i + 77), 1'b1);
      for (int i = 0; i < 16; i++) check("R9 swapped store", mem[8'h80 + i], swp(fpat(i + 77)));
      host_write(2'd2, 16'h0100, 1'b1);
      for (int i = 0; i < 16; i++) begin
         host_read(2'd0, r); check("R9 swapped round trip", r, fpat(i + 77));
      end
      host_write(2'd2, 16'h0040, 1'b1);
      host_read(2'd0, r); check("R9 swapped read of plain data", r, swp(fpat(0)));
      cfg_swap = 1'b0;

      // R2 strobes with chip select high
      host_write(2'd2, 16'h0030, 1'b1);
      host_write(2'd2, 16'h0300, 1'b0);
      host_read(2'd2, r); check("R2 pointer load ignored without cs", r, 16'h0030);
      host_write(2'd0, 16'hDEAD, 1'b0);
      check("R2 memory untouched without cs", mem[8'h18], 16'h0000);
      host_read(2'd2, r); check("R2 pointer not stepped without cs", r, 16'h0030);

      // R6 outgoing mailbox
      @(negedge clk); loc_out_wr = 1'b1; loc_out_data = 16'hBEEF;
      @(negedge clk); loc_out_wr = 1'b0;
      @(negedge clk);
      check("R6 irq raised", {15'h0, host_irq}, 16'h1);
      host_read(2'd3, r); check("R6 status out flag", r, {14'h2A5C, 2'b01});
      host_read(2'd1, r); check("R6 mailbox word", r, 16'hBEEF);
      check("R6 irq cleared by host read", {15'h0, host_irq}, 16'h0);

      // R7 incoming mailbox
      host_write(2'd1, 16'h5AA5, 1'b1);
      check("R7 single pulse", 16'(pulse_cnt), 16'd1);
      check("R7 incoming word", loc_in_data, 16'h5AA5);
      host_read(2'd3, r); check("R7 status in flag", r, {14'h2A5C, 2'b10});
      @(negedge clk); loc_in_rd = 1'b1;
      @(negedge clk); loc_in_rd = 1'b0;
      host_read(2'd3, r); check("R7 in flag cleared", r, {14'h2A5C, 2'b00});

      // R8 status write ignored and status input sweep
      host_write(2'd3, 16'hFFFF, 1'b1);
      host_read(2'd3, r); check("R8 status write ignored", r, {14'h2A5C, 2'b00});
      host_read(2'd2, r); check("R8 pointer untouched by status write", r, 16'h0030);
      for (int k = 0; k < 8; k++) begin
         stat_in = 14'(k * 14'h0A37 + 1);
         host_read(2'd3, r); check("R8 status inputs", r, {14'(k * 14'h0A37 + 1), 2'b00});
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule